// File: doc/BRIEF.md
# Two-Wire Bus Master Clock Rate Generator

This block makes the serial clock that a byte-oriented two-wire bus master drives onto the bus. Its input clock is the oscillator clock. A 3-bit rate code and an enable bit are read from fixed positions of an 8-bit control byte. Seven code values pick a fixed oscillator divide ratio. The eighth value takes its rate from an internal 8-bit auto-reload timer instead. That timer is clocked at one twelfth of the oscillator rate, and its overflow pulses are divided by eight.

The block drives a square wave on `scl_out`. It also pulses `edge_tick` for one cycle each time that wave changes level, so the framing logic that follows can line up its data changes with the clock. While the enable bit is clear, the clock rests high, which is the bus idle level. A new rate code is picked up only at the start of a clock period, so a period already under way is never cut short or stretched.

Top module: `sclk_rate_gen`

## Requirements
- R1: After reset, and in the cycle after any clock edge that samples the enable bit (control bit 6) at 0, `scl_out` is 1 and `edge_tick` is 0. This holds for as long as enable stays 0.
- R2: The rate code is {control bit 7, control bit 1, control bit 0}. With enable set, codes 000, 001, 010 and 011 give a `scl_out` period of 256, 224, 192 and 160 clock cycles respectively.
- R3: Codes 100, 101 and 110 give a period of 960, 120 and 60 clock cycles respectively.
- R4: For every fixed code, `scl_out` is high for exactly half of the period and low for the other half. The high phase comes first in each period.
- R5: Code 111 gives a period of 96 × (256 − R) cycles, where R is `reload_val`, and a high phase of 48 × (256 − R) cycles. The allowed range of R is 0 to 254. A value of 255 must not be presented while code 111 is enabled.
- R6: `edge_tick` is 1 in exactly the cycles in which `scl_out` has just taken a new level while enabled. It is never high in two cycles in a row.
- R7: A rate code change takes effect only at the next rising edge of `scl_out`. The period in progress keeps its old high and low lengths, and the period that follows uses the new code.
- R8: Control bits 5 to 2 have no effect on the clock.

Ports:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_byte | input | 8 | Control byte: bit 7 is the rate code MSB, bit 6 is the enable, bits 1:0 are the rate code LSBs |
| reload_val | input | TMR_W | Auto-reload value for the timer path (code 111) |
| scl_out | output | 1 | Generated serial clock, high when idle |
| edge_tick | output | 1 | One-cycle pulse in the first cycle of each new `scl_out` level |

## Verification
Both outputs come from registers. An enable or code value sampled at clock edge k therefore shows at the outputs just after edge k, and the bench samples on the falling edge that follows. Period and high-phase lengths are taken as the difference between free-running cycle counts at the falling edges where a tick is seen with the new level, so register latency cancels out of every measured length. For a code change, the bench counts on the new code from the first rising edge after the change, where R7 says it takes effect. For code 111, timing is measured only from that boundary onward, because the timer is cleared or reloaded there. Disable checks sample the falling edge right after the edge that saw enable low.

// File: rtl/sclk_rate_pkg.sv
package sclk_rate_pkg;

   typedef logic [2:0] rate_code_t;

   localparam rate_code_t TIMER_CODE    = 3'b111;
   localparam int unsigned MAX_FIXED_DIV = 960;

   // Oscillator cycles per full clock period for each fixed code.
   // The timer code falls back to the slowest ratio when no timer path is built.
   function automatic int unsigned fixed_div(input rate_code_t code);
      case (code)
         3'b000:  return 256;
         3'b001:  return 224;
         3'b010:  return 192;
         3'b011:  return 160;
         3'b100:  return 960;
         3'b101:  return 120;
         3'b110:  return 60;
         default: return MAX_FIXED_DIV;
      endcase
   endfunction

endpackage

// File: rtl/sclk_half_counter.sv
module sclk_half_counter #(
   parameter int unsigned CNT_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic [CNT_W-1:0] half_len,
   output logic             hit
);

   logic [CNT_W-1:0] cnt_q;
   logic             at_end;

   assign at_end = (cnt_q == half_len - 1'b1);
   assign hit    = !clear && at_end;

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         cnt_q <= '0;
      end else if (at_end) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R4
   hit_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> !hit);

endmodule

// File: rtl/sclk_reload_timer.sv
module sclk_reload_timer #(
   parameter int unsigned PRESCALE = 12,
   parameter int unsigned TMR_W    = 8,
   parameter int unsigned OVF_HALF = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic [TMR_W-1:0] reload,
   output logic             half_hit
);

   localparam int unsigned PRE_W = $clog2(PRESCALE);
   localparam int unsigned OVF_W = $clog2(OVF_HALF);

   logic [PRE_W-1:0] pre_q;
   logic [TMR_W-1:0] tmr_q;
   logic [OVF_W-1:0] ovf_q;
   logic             tick, ovf;

   assign tick     = !clear && (pre_q == PRE_W'(PRESCALE - 1));
   assign ovf      = tick && (tmr_q == '1);
   assign half_hit = ovf && (ovf_q == OVF_W'(OVF_HALF - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pre_q <= '0;
         tmr_q <= '0;
         ovf_q <= '0;
      end else if (clear) begin
         pre_q <= '0;
         tmr_q <= reload;
         ovf_q <= '0;
      end else begin
         pre_q <= tick ? '0 : pre_q + 1'b1;
         if (ovf) begin
            tmr_q <= reload;
            ovf_q <= half_hit ? '0 : ovf_q + 1'b1;
         end else if (tick) begin
            tmr_q <= tmr_q + 1'b1;
         end
      end
   end

   // R5
   reload_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clear |-> (reload != '1));

endmodule

// File: rtl/sclk_rate_gen.sv
module sclk_rate_gen
   import sclk_rate_pkg::*;
#(
   parameter int unsigned PRESCALE   = 12,
   parameter int unsigned TMR_W      = 8,
   parameter int unsigned POST_DIV   = 8,
   parameter bit          TIMER_PATH = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [7:0]       ctrl_byte,
   input  logic [TMR_W-1:0] reload_val,
   output logic             scl_out,
   output logic             edge_tick
);

   localparam int unsigned CNT_W    = $clog2(MAX_FIXED_DIV / 2 + 1);
   localparam int unsigned OVF_HALF = POST_DIV / 2;
   localparam int unsigned EN_BIT   = 6;
   localparam int unsigned MSB_BIT  = 7;

   if (PRESCALE < 2) begin : g_bad_prescale
      $error("sclk_rate_gen: PRESCALE must be at least 2");
   end
   if (POST_DIV < 4 || (POST_DIV % 2) != 0) begin : g_bad_post_div
      $error("sclk_rate_gen: POST_DIV must be even and at least 4");
   end
   if (TMR_W < 2) begin : g_bad_tmr_w
      $error("sclk_rate_gen: TMR_W must be at least 2");
   end

   logic             en;
   rate_code_t       req_code;
   rate_code_t       active_q;
   logic             scl_q, tick_q;
   logic             use_tmr, fix_hit, tmr_hit, hit;
   logic [CNT_W-1:0] half_len;
   logic             unused_ctrl_bits;

   assign en               = ctrl_byte[EN_BIT];
   assign req_code         = {ctrl_byte[MSB_BIT], ctrl_byte[1:0]};
   assign unused_ctrl_bits = ^ctrl_byte[5:2];

   assign use_tmr  = TIMER_PATH && (active_q == TIMER_CODE);
   assign half_len = CNT_W'(fixed_div(active_q) / 2);

   sclk_half_counter #(
      .CNT_W (CNT_W)
   ) i_half_counter (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (!en || use_tmr),
      .half_len (half_len),
      .hit      (fix_hit)
   );

   if (TIMER_PATH) begin : g_timer
      sclk_reload_timer #(
         .PRESCALE (PRESCALE),
         .TMR_W    (TMR_W),
         .OVF_HALF (OVF_HALF)
      ) i_reload_timer (
         .clk      (clk),
         .rst_n    (rst_n),
         .clear    (!en || !use_tmr),
         .reload   (reload_val),
         .half_hit (tmr_hit)
      );
   end else begin : g_no_timer
      logic unused_reload;
      assign unused_reload = ^reload_val;
      assign tmr_hit       = 1'b0;
   end

   assign hit = use_tmr ? tmr_hit : fix_hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         scl_q    <= 1'b1;
         tick_q   <= 1'b0;
         active_q <= '0;
      end else if (!en) begin
         scl_q    <= 1'b1;
         tick_q   <= 1'b0;
         active_q <= req_code;
      end else begin
         tick_q <= hit;
         if (hit) begin
            scl_q <= ~scl_q;
            if (!scl_q) begin
               active_q <= req_code;
            end
         end
      end
   end

   assign scl_out   = scl_q;
   assign edge_tick = tick_q;

   // R1
   idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(en) |-> (scl_out && !edge_tick));

   // R6
   tick_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      edge_tick |-> (scl_out != $past(scl_out)));

   // R6
   edge_has_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(en) && (scl_out != $past(scl_out))) |-> edge_tick);

   // R7
   code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q != $past(active_q)) |-> (!$past(en) || (scl_q && !$past(scl_q))));

endmodule

// File: tb/test_sclk_rate_gen.sv
module test_sclk_rate_gen;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] ctrl_byte = 8'h00;
   logic [7:0] reload_val = 8'h00;
   logic       scl_out, edge_tick;

   int cyc = 0;
   int n_tests = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   sclk_rate_gen i_sclk_rate_gen (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctrl_byte  (ctrl_byte),
      .reload_val (reload_val),
      .scl_out    (scl_out),
      .edge_tick  (edge_tick)
   );

   function automatic logic [7:0] mk_ctrl(input logic [2:0] code, input logic en,
                                          input logic [3:0] pad);
      return {code[2], en, pad, code[1:0]};
   endfunction

   function automatic int exp_period(input int code);
      case (code)
         0: return 256;
         1: return 224;
         2: return 192;
         3: return 160;
         4: return 960;
         5: return 120;
         default: return 60;
      endcase
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic wait_rise(output int t);
      do @(negedge clk); while (!(edge_tick && scl_out));
      t = cyc;
   endtask

   task automatic wait_fall(output int t);
      do @(negedge clk); while (!(edge_tick && !scl_out));
      t = cyc;
   endtask

   task automatic t_reset;
      @(negedge clk);
      check(scl_out == 1'b1, "R1", "scl after reset", int'(scl_out), 1);
      check(edge_tick == 1'b0, "R1", "tick after reset", int'(edge_tick), 0);
   endtask

   // Measure one full period with the given code; R2/R3 period, R4 high half
   task automatic t_fixed(input int code, input logic [3:0] pad, input string req);
      int b, f, r;
      @(negedge clk);
      ctrl_byte = mk_ctrl(3'(code), 1'b1, pad);
      wait_rise(b);
      wait_fall(f);
      wait_rise(r);
      check((r - b) == exp_period(code), req, $sformatf("period code %0d", code),
            r - b, exp_period(code));
      check((f - b) == exp_period(code) / 2, "R4", $sformatf("high code %0d", code),
            f - b, exp_period(code) / 2);
   endtask

   task automatic t_timer(input int rv);
      int b, f, r;
      @(negedge clk);
      reload_val = 8'(rv);
      ctrl_byte  = mk_ctrl(3'b111, 1'b1, 4'h0);
      wait_rise(b);
      wait_rise(b);
      wait_fall(f);
      wait_rise(r);
      check((r - b) == 96 * (256 - rv), "R5", $sformatf("period reload %0d", rv),
            r - b, 96 * (256 - rv));
      check((f - b) == 48 * (256 - rv), "R5", $sformatf("high reload %0d", rv),
            f - b, 48 * (256 - rv));
   endtask

   // R7: change the code just after a rising edge; old period completes
   task automatic t_change;
      int b, f, r1, r2;
      @(negedge clk);
      ctrl_byte = mk_ctrl(3'b000, 1'b1, 4'h0);
      wait_rise(b);
      wait_rise(b);
      ctrl_byte = mk_ctrl(3'b110, 1'b1, 4'h0);
      wait_fall(f);
      wait_rise(r1);
      wait_rise(r2);
      check((f - b) == 128, "R7", "old high kept", f - b, 128);
      check((r1 - b) == 256, "R7", "old period kept", r1 - b, 256);
      check((r2 - r1) == 60, "R7", "new period used", r2 - r1, 60);
   endtask

   // R6: tick matches every level change, never two in a row
   task automatic t_tick;
      logic prev_scl, prev_tick;
      int bad = 0;
      int ticks = 0;
      @(negedge clk);
      ctrl_byte = mk_ctrl(3'b110, 1'b1, 4'h0);
      prev_scl  = scl_out;
      prev_tick = edge_tick;
      for (int i = 0; i < 300; i++) begin
         @(negedge clk);
         if ((scl_out != prev_scl) != edge_tick) bad++;
         if (edge_tick && prev_tick) bad++;
         if (edge_tick) ticks++;
         prev_scl  = scl_out;
         prev_tick = edge_tick;
      end
      check(bad == 0, "R6", "tick/level mismatches", bad, 0);
      check(ticks >= 9, "R6", "tick count in 300 cycles", ticks, 10);
   endtask

   // R1: clearing enable during the low phase forces idle high at once
   task automatic t_disable;
      int f;
      int seen = 0;
      @(negedge clk);
      ctrl_byte = mk_ctrl(3'b101, 1'b1, 4'h0);
      wait_fall(f);
      ctrl_byte = mk_ctrl(3'b101, 1'b0, 4'h0);
      @(negedge clk);
      check(scl_out == 1'b1, "R1", "scl after disable", int'(scl_out), 1);
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (edge_tick || !scl_out) seen++;
      end
      check(seen == 0, "R1", "activity while disabled", seen, 0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got %0d cycles expected completion", cyc);
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      for (int c = 0; c < 4; c++) t_fixed(c, 4'h0, "R2");
      for (int c = 4; c < 7; c++) t_fixed(c, 4'h0, "R3");
      // R8: padding bits 5..2 set must not change the rate
      t_fixed(5, 4'hF, "R8");
      t_fixed(1, 4'hA, "R8");
      t_change();
      t_tick();
      t_disable();
      t_timer(254);
      t_timer(128);
      t_timer(0);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule